// File: doc/BRIEF.md
# Serial Mode-Register Interface with Staged Commit

This block takes 48-bit command frames from a three-wire serial port made of a strobe, a serial clock and a data line. All three are assumed to be already synchronous to the system clock. While the strobe is low, the block shifts in one bit on each rising edge of the serial clock, starting with bit d00. The rising edge of the strobe ends the frame. The block accepts the frame only if it holds exactly 48 bits and its first eight bits carry the chip-enable code. A 2-bit category field then sends the payload to one of two banks: the control bank (timing setup) or the shutter bank (exposure counts).

Accepted fields do not drive the outputs directly. They are first written into shadow registers. Each field moves from its shadow register to the live output register at its own event:
- The low-power state is applied right away when the strobe rises.
- Drive mode, timing pattern and frame-shift count wait for a falling edge of vertical sync.
- Shutter mode, ADC clock phase and the whole shutter bank wait for a falling edge of horizontal sync during the readout line.

While a long exposure is in progress, an input from the shutter logic holds back every sync-driven commit. The shadow registers keep the newest data and commit at the first allowed event after the exposure ends.

Top module: `ser_mode_regs`

## Requirements
- R1: While rst_ni is low, every live output is zero, except that adc_phase_o is 2'b01 (the 90-degree code) and power_o is 2'b00 (normal). The shadow registers start at the same values.
- R2: While strobe_i is low, a rising edge of sclk_i samples sdata_i. The first sampled bit is d00. A rising edge of strobe_i closes the frame. A frame with any bit count other than 48 changes no output, now or at any later event.
- R3: A frame is accepted only if d00..d07 read 1,0,0,0,0,0,0,1. Any other code leaves all outputs unchanged.
- R4: The category field d09:d08 selects the target. 00 writes the control shadow, using these fields: d10..d12 drive mode (d10 LSB), d13..d14 shutter mode, d15 pattern, d16..d23 frame shift (d23 MSB), d36..d37 ADC phase, d38..d39 standby. 01 writes the shutter shadow, using these fields: d10..d19 vertical count, d20..d31 horizontal count, d32..d41 sub-pulse field index (LSB first). 10 and 11 have no effect.
- R5: An accepted control frame sets power_o in the clock cycle after the strobe rise, whatever the value of exposure_busy_i. If d38=0, power_o becomes 00 (normal). If d39:d38=01, it becomes 01 (sleep). If d39:d38=11, it becomes 11 (standby). The value 10 never appears.
- R6: drive_mode_o, pattern_o and frame_shift_o take their shadow values one cycle after the clock edge that first samples vsync_i low after high. They change at no other time.
- R7: shutter_mode_o, adc_phase_o and the three shutter outputs take their shadow values one cycle after the clock edge that first samples hsync_i low after high, but only if readout_i is high at that edge. A falling edge of hsync_i with readout_i low commits nothing.
- R8: If exposure_busy_i is high at a sync event, that event commits nothing. The shadow contents are kept and commit at the next event that is not blocked.
- R9: A later accepted frame of a category replaces the earlier shadow contents of that category before the commit. Frames of the two categories within one vertical period do not disturb each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strobe_i | input | 1 | Frame strobe; low while a frame is shifted in, rising edge ends it |
| sclk_i | input | 1 | Serial bit clock; data sampled on its rising edge |
| sdata_i | input | 1 | Serial data, d00 first |
| vsync_i | input | 1 | Vertical sync; falling edge commits the frame-rate fields |
| hsync_i | input | 1 | Horizontal sync; falling edge in the readout line commits line fields |
| readout_i | input | 1 | High during the readout line |
| exposure_busy_i | input | 1 | High while a multi-field exposure holds back commits |
| drive_mode_o | output | 3 | Live drive mode |
| shutter_mode_o | output | 2 | Live shutter mode |
| pattern_o | output | 1 | Live timing pattern: 0 = 60 Hz style, 1 = 50 Hz style |
| frame_shift_o | output | 8 | Live frame-shift stage count |
| adc_phase_o | output | 2 | Live ADC clock phase code (0/90/180/270 degrees) |
| shut_vcnt_o | output | 10 | Live shutter vertical-period count |
| shut_hcnt_o | output | 12 | Live shutter horizontal-period count |
| shut_line_o | output | 10 | Live field index for sub-pulse output |
| power_o | output | 2 | Power state: 00 normal, 01 sleep, 11 standby |

## Verification
On every cycle, the assertions check the timing rules:
- The frame-rate fields move only right after an unblocked vertical-sync fall.
- The line fields move only right after an unblocked horizontal-sync fall in the readout line.
- The power state moves only right after a strobe rise and never takes the unused code.

Only the bench scenarios can show which values arrive. These include the bit order and field positions, the rejection of short, long, wrongly addressed and test-category frames, the hand-over from shadow to live after a blocked event, and the overwrite of one frame by a later frame of the same category.

// File: rtl/smr_pkg.sv
package smr_pkg;
  localparam int unsigned FRAME_BITS = 48;
  localparam int unsigned CODE_W     = 8;
  localparam logic [CODE_W-1:0] CHIP_CODE = 8'b1000_0001;

  localparam int unsigned DM_W  = 3;
  localparam int unsigned SM_W  = 2;
  localparam int unsigned FS_W  = 8;
  localparam int unsigned ADC_W = 2;
  localparam int unsigned VC_W  = 10;
  localparam int unsigned HC_W  = 12;
  localparam int unsigned SL_W  = 10;

  // bit positions inside the frame, d00 = bit 0
  localparam int unsigned CAT_LSB  = 8;
  localparam int unsigned DM_LSB   = 10;
  localparam int unsigned SM_LSB   = 13;
  localparam int unsigned PAT_BIT  = 15;
  localparam int unsigned FS_LSB   = 16;
  localparam int unsigned ADC_LSB  = 36;
  localparam int unsigned STB_LSB  = 38;
  localparam int unsigned VC_LSB   = 10;
  localparam int unsigned HC_LSB   = 20;
  localparam int unsigned SL_LSB   = 32;

  localparam logic [ADC_W-1:0] ADC_RST = 2'b01;

  typedef enum logic [1:0] {
    PWR_RUN   = 2'b00,
    PWR_SLEEP = 2'b01,
    PWR_STBY  = 2'b11
  } pwr_e;

  typedef enum logic [1:0] {
    CAT_CTRL = 2'b00,
    CAT_SHUT = 2'b01
  } cat_e;

  typedef struct packed {
    logic [DM_W-1:0]  drive_mode;
    logic [SM_W-1:0]  shut_mode;
    logic             pattern;
    logic [FS_W-1:0]  frame_shift;
    logic [ADC_W-1:0] adc_phase;
  } ctrl_t;

  typedef struct packed {
    logic [VC_W-1:0] vcnt;
    logic [HC_W-1:0] hcnt;
    logic [SL_W-1:0] sline;
  } shut_t;

  localparam ctrl_t CTRL_RST = '{drive_mode: '0, shut_mode: '0, pattern: 1'b0,
                                 frame_shift: '0, adc_phase: ADC_RST};
  localparam shut_t SHUT_RST = '0;
endpackage

// File: rtl/smr_serial_rx.sv
module smr_serial_rx #(
  parameter int unsigned FRAME_BITS = 48
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  strobe_i,
  input  logic                  sclk_i,
  input  logic                  sdata_i,
  output logic [FRAME_BITS-1:0] frame_o,
  output logic                  done_o
);
  localparam int unsigned CW = $clog2(FRAME_BITS + 2);
  localparam logic [CW-1:0] CNT_FULL = CW'(FRAME_BITS);
  localparam logic [CW-1:0] CNT_OVER = CW'(FRAME_BITS + 1);

  logic                  stb_q, sclk_q;
  logic [CW-1:0]         cnt_q;
  logic [FRAME_BITS-1:0] sh_q;
  logic                  sclk_rise, stb_rise;

  assign sclk_rise = sclk_i & ~sclk_q;
  assign stb_rise  = strobe_i & ~stb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q  <= 1'b1;
      sclk_q <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
    end else begin
      stb_q  <= strobe_i;
      sclk_q <= sclk_i;
      if (strobe_i) begin
        cnt_q <= '0;
      end else if (sclk_rise) begin
        // saturate one past full so long frames stay rejected
        if (cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;
        sh_q <= {sdata_i, sh_q[FRAME_BITS-1:1]};
      end
    end
  end

  assign done_o  = stb_rise && (cnt_q == CNT_FULL);
  assign frame_o = sh_q;
endmodule

// File: rtl/smr_decode.sv
module smr_decode
  import smr_pkg::*;
(
  input  logic                  done_i,
  input  logic [FRAME_BITS-1:0] frame_i,
  output logic                  ctrl_wr_o,
  output logic                  shut_wr_o,
  output ctrl_t                 ctrl_o,
  output shut_t                 shut_o,
  output pwr_e                  pwr_o
);
  logic       code_ok;
  logic [1:0] cat;
  logic [1:0] stb;

  assign code_ok = (frame_i[CODE_W-1:0] == CHIP_CODE);
  assign cat     = frame_i[CAT_LSB +: 2];
  assign stb     = frame_i[STB_LSB +: 2];

  assign ctrl_wr_o = done_i && code_ok && (cat == CAT_CTRL);
  assign shut_wr_o = done_i && code_ok && (cat == CAT_SHUT);

  always_comb begin
    ctrl_o.drive_mode  = frame_i[DM_LSB  +: DM_W];
    ctrl_o.shut_mode   = frame_i[SM_LSB  +: SM_W];
    ctrl_o.pattern     = frame_i[PAT_BIT];
    ctrl_o.frame_shift = frame_i[FS_LSB  +: FS_W];
    ctrl_o.adc_phase   = frame_i[ADC_LSB +: ADC_W];
    shut_o.vcnt        = frame_i[VC_LSB  +: VC_W];
    shut_o.hcnt        = frame_i[HC_LSB  +: HC_W];
    shut_o.sline       = frame_i[SL_LSB  +: SL_W];
  end

  always_comb begin
    if (!stb[0])     pwr_o = PWR_RUN;
    else if (stb[1]) pwr_o = PWR_STBY;
    else             pwr_o = PWR_SLEEP;
  end
endmodule

// File: rtl/smr_commit.sv
module smr_commit
  import smr_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  ctrl_wr_i,
  input  logic  shut_wr_i,
  input  ctrl_t ctrl_i,
  input  shut_t shut_i,
  input  pwr_e  pwr_i,
  input  logic  vsync_i,
  input  logic  hsync_i,
  input  logic  readout_i,
  input  logic  busy_i,
  output ctrl_t ctrl_o,
  output shut_t shut_o,
  output pwr_e  pwr_o
);
  ctrl_t ctrl_sh_q, ctrl_lv_q;
  shut_t shut_sh_q, shut_lv_q;
  pwr_e  pwr_q;
  logic  vs_q, hs_q;
  logic  v_go, h_go;

  assign v_go = vs_q & ~vsync_i & ~busy_i;
  assign h_go = hs_q & ~hsync_i & readout_i & ~busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vs_q <= 1'b0;
      hs_q <= 1'b0;
    end else begin
      vs_q <= vsync_i;
      hs_q <= hsync_i;
    end
  end

  // shadow banks: newest accepted frame per category
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_sh_q <= CTRL_RST;
      shut_sh_q <= SHUT_RST;
    end else begin
      if (ctrl_wr_i) ctrl_sh_q <= ctrl_i;
      if (shut_wr_i) shut_sh_q <= shut_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_q <= PWR_RUN;
    end else if (ctrl_wr_i) begin
      pwr_q <= pwr_i;
    end
  end

  // frame-rate fields: vertical event
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_lv_q.drive_mode  <= CTRL_RST.drive_mode;
      ctrl_lv_q.pattern     <= CTRL_RST.pattern;
      ctrl_lv_q.frame_shift <= CTRL_RST.frame_shift;
    end else if (v_go) begin
      ctrl_lv_q.drive_mode  <= ctrl_sh_q.drive_mode;
      ctrl_lv_q.pattern     <= ctrl_sh_q.pattern;
      ctrl_lv_q.frame_shift <= ctrl_sh_q.frame_shift;
    end
  end

  // line fields: horizontal event inside the readout line
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_lv_q.shut_mode <= CTRL_RST.shut_mode;
      ctrl_lv_q.adc_phase <= CTRL_RST.adc_phase;
      shut_lv_q           <= SHUT_RST;
    end else if (h_go) begin
      ctrl_lv_q.shut_mode <= ctrl_sh_q.shut_mode;
      ctrl_lv_q.adc_phase <= ctrl_sh_q.adc_phase;
      shut_lv_q           <= shut_sh_q;
    end
  end

  assign ctrl_o = ctrl_lv_q;
  assign shut_o = shut_lv_q;
  assign pwr_o  = pwr_q;
endmodule

// File: rtl/ser_mode_regs.sv
module ser_mode_regs
  import smr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic             sclk_i,
  input  logic             sdata_i,
  input  logic             vsync_i,
  input  logic             hsync_i,
  input  logic             readout_i,
  input  logic             exposure_busy_i,
  output logic [DM_W-1:0]  drive_mode_o,
  output logic [SM_W-1:0]  shutter_mode_o,
  output logic             pattern_o,
  output logic [FS_W-1:0]  frame_shift_o,
  output logic [ADC_W-1:0] adc_phase_o,
  output logic [VC_W-1:0]  shut_vcnt_o,
  output logic [HC_W-1:0]  shut_hcnt_o,
  output logic [SL_W-1:0]  shut_line_o,
  output logic [1:0]       power_o
);
  logic [FRAME_BITS-1:0] frame;
  logic                  done, ctrl_wr, shut_wr;
  ctrl_t                 ctrl_new, ctrl_live;
  shut_t                 shut_new, shut_live;
  pwr_e                  pwr_new, pwr_live;

  smr_serial_rx #(.FRAME_BITS(FRAME_BITS)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(strobe_i),
    .sclk_i  (sclk_i),
    .sdata_i (sdata_i),
    .frame_o (frame),
    .done_o  (done)
  );

  smr_decode u_dec (
    .done_i   (done),
    .frame_i  (frame),
    .ctrl_wr_o(ctrl_wr),
    .shut_wr_o(shut_wr),
    .ctrl_o   (ctrl_new),
    .shut_o   (shut_new),
    .pwr_o    (pwr_new)
  );

  smr_commit u_cmt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ctrl_wr_i(ctrl_wr),
    .shut_wr_i(shut_wr),
    .ctrl_i   (ctrl_new),
    .shut_i   (shut_new),
    .pwr_i    (pwr_new),
    .vsync_i  (vsync_i),
    .hsync_i  (hsync_i),
    .readout_i(readout_i),
    .busy_i   (exposure_busy_i),
    .ctrl_o   (ctrl_live),
    .shut_o   (shut_live),
    .pwr_o    (pwr_live)
  );

  assign drive_mode_o   = ctrl_live.drive_mode;
  assign shutter_mode_o = ctrl_live.shut_mode;
  assign pattern_o      = ctrl_live.pattern;
  assign frame_shift_o  = ctrl_live.frame_shift;
  assign adc_phase_o    = ctrl_live.adc_phase;
  assign shut_vcnt_o    = shut_live.vcnt;
  assign shut_hcnt_o    = shut_live.hcnt;
  assign shut_line_o    = shut_live.sline;
  assign power_o        = pwr_live;
endmodule

// File: rtl/ser_mode_regs_chk.sv
module ser_mode_regs_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        strobe_i,
  input logic        vsync_i,
  input logic        hsync_i,
  input logic        readout_i,
  input logic        exposure_busy_i,
  input logic [2:0]  drive_mode_o,
  input logic        pattern_o,
  input logic [7:0]  frame_shift_o,
  input logic [1:0]  shutter_mode_o,
  input logic [1:0]  adc_phase_o,
  input logic [9:0]  shut_vcnt_o,
  input logic [11:0] shut_hcnt_o,
  input logic [1:0]  power_o
);
  logic vs_d, hs_d, st_d;
  logic v_ok, h_ok, s_rose, v_blk;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vs_d <= 1'b0; hs_d <= 1'b0; st_d <= 1'b1;
      v_ok <= 1'b0; h_ok <= 1'b0; s_rose <= 1'b0; v_blk <= 1'b0;
    end else begin
      vs_d   <= vsync_i;
      hs_d   <= hsync_i;
      st_d   <= strobe_i;
      v_ok   <= vs_d & ~vsync_i & ~exposure_busy_i;
      v_blk  <= vs_d & ~vsync_i & exposure_busy_i;
      h_ok   <= hs_d & ~hsync_i & readout_i & ~exposure_busy_i;
      s_rose <= ~st_d & strobe_i;
    end
  end

  assert_vert_fields_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($stable(drive_mode_o) && $stable(pattern_o) && $stable(frame_shift_o)) |-> v_ok);

  assert_line_fields_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($stable(shut_vcnt_o) && $stable(shut_hcnt_o) && $stable(shutter_mode_o)) |-> h_ok);

  assert_adc_phase_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(adc_phase_o) |-> h_ok);

  assert_blocked_vert_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_blk |-> $stable(drive_mode_o) && $stable(frame_shift_o));

  assert_power_edge_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(power_o) |-> s_rose);

  assert_power_code_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    power_o != 2'b10);
endmodule

bind ser_mode_regs ser_mode_regs_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .strobe_i       (strobe_i),
  .vsync_i        (vsync_i),
  .hsync_i        (hsync_i),
  .readout_i      (readout_i),
  .exposure_busy_i(exposure_busy_i),
  .drive_mode_o   (drive_mode_o),
  .pattern_o      (pattern_o),
  .frame_shift_o  (frame_shift_o),
  .shutter_mode_o (shutter_mode_o),
  .adc_phase_o    (adc_phase_o),
  .shut_vcnt_o    (shut_vcnt_o),
  .shut_hcnt_o    (shut_hcnt_o),
  .power_o        (power_o)
);

// File: tb/sim_ser_mode_regs.sv
`timescale 1ns/1ps
module sim_ser_mode_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe = 1'b1, sclk = 1'b0, sdata = 1'b0;
  logic vsync = 1'b0, hsync = 1'b0, readout = 1'b0, busy = 1'b0;
  logic [2:0]  dm;
  logic [1:0]  smd, adc, pwr;
  logic        pat;
  logic [7:0]  fs;
  logic [9:0]  vc, sl;
  logic [11:0] hc;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ser_mode_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe), .sclk_i(sclk), .sdata_i(sdata),
    .vsync_i(vsync), .hsync_i(hsync), .readout_i(readout), .exposure_busy_i(busy),
    .drive_mode_o(dm), .shutter_mode_o(smd), .pattern_o(pat), .frame_shift_o(fs),
    .adc_phase_o(adc), .shut_vcnt_o(vc), .shut_hcnt_o(hc), .shut_line_o(sl),
    .power_o(pwr)
  );

  // model: ctrl = {dm3,smd2,pat1,fs8,adc2}, shut = {vc10,hc12,sl10}
  logic [15:0] m_csh, m_clv;
  logic [31:0] m_ssh, m_slv;
  logic [1:0]  m_pwr;

  function automatic logic [47:0] mk_ctrl(logic [2:0] d, logic [1:0] s, logic p,
                                          logic [7:0] f, logic [1:0] a, logic [1:0] st);
    logic [47:0] r = '0;
    r[7:0] = 8'b1000_0001; r[9:8] = 2'b00;
    r[12:10] = d; r[14:13] = s; r[15] = p; r[23:16] = f; r[37:36] = a; r[39:38] = st;
    return r;
  endfunction

  function automatic logic [47:0] mk_shut(logic [9:0] v, logic [11:0] h, logic [9:0] l);
    logic [47:0] r = '0;
    r[7:0] = 8'b1000_0001; r[9:8] = 2'b01;
    r[19:10] = v; r[31:20] = h; r[41:32] = l;
    return r;
  endfunction

  function automatic logic [1:0] exp_pwr(logic [1:0] st);
    if (!st[0]) return 2'b00;
    return st[1] ? 2'b11 : 2'b01;
  endfunction

  task automatic model_frame(logic [47:0] f, int nb);
    if (nb != 48 || f[7:0] != 8'b1000_0001) return;
    if (f[9:8] == 2'b00) begin
      m_csh = {f[12:10], f[14:13], f[15], f[23:16], f[37:36]};
      m_pwr = exp_pwr(f[39:38]);
    end else if (f[9:8] == 2'b01) begin
      m_ssh = {f[19:10], f[31:20], f[41:32]};
    end
  endtask

  function automatic logic [49:0] act_all();
    return {dm, smd, pat, fs, adc, vc, hc, sl, pwr};
  endfunction

  function automatic logic [49:0] exp_all();
    return {m_clv[15:13], m_clv[12:11], m_clv[10], m_clv[9:2], m_clv[1:0], m_slv, m_pwr};
  endfunction

  task automatic chk(string req, logic [49:0] a, logic [49:0] e);
    n_cmp++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, a, e);
    end
  endtask

  task automatic chk_all(string req);
    chk(req, act_all(), exp_all());
  endtask

  task automatic send(logic [47:0] f, int nb);
    @(negedge clk) strobe = 1'b0;
    for (int i = 0; i < nb; i++) begin
      @(negedge clk) sdata = (i < 48) ? f[i] : 1'b0; sclk = 1'b0;
      @(negedge clk) sclk = 1'b1;
      @(negedge clk);
    end
    @(negedge clk) sclk = 1'b0;
    @(negedge clk) strobe = 1'b1;
    model_frame(f, nb);
  endtask

  task automatic vs_evt(bit b);
    @(negedge clk) busy = b; vsync = 1'b1;
    @(negedge clk);
    @(negedge clk) vsync = 1'b0;
    @(negedge clk) busy = 1'b0;
    if (!b) m_clv = {m_csh[15:13], m_clv[12:11], m_csh[10:2], m_clv[1:0]};
  endtask

  task automatic hs_evt(bit ro, bit b);
    @(negedge clk) busy = b; readout = ro; hsync = 1'b1;
    @(negedge clk);
    @(negedge clk) hsync = 1'b0;
    @(negedge clk) busy = 1'b0; readout = 1'b0;
    if (ro && !b) begin
      m_clv = {m_clv[15:13], m_csh[12:11], m_clv[10:2], m_csh[1:0]};
      m_slv = m_ssh;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [47:0] f;
    void'($urandom(32'd1234));
    m_csh = {3'd0, 2'd0, 1'b0, 8'd0, 2'b01}; m_clv = m_csh;
    m_ssh = '0; m_slv = '0; m_pwr = 2'b00;
    repeat (3) @(negedge clk);
    chk_all("R1 reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_all("R1 after release");
    vs_evt(0); hs_evt(1, 0);
    chk_all("R1 shadow reset values");

    // control frame; power applies one cycle after strobe rise
    send(mk_ctrl(3'd5, 2'd2, 1'b1, 8'h69, 2'd3, 2'b01), 48);
    @(negedge clk);
    chk("R5 sleep one cycle after strobe", {48'd0, pwr}, {48'd0, 2'b01});
    chk_all("R6 no commit before vsync");
    hs_evt(0, 0);
    chk_all("R7 hsync fall outside readout ignored");
    hs_evt(1, 0);
    chk_all("R7 line fields commit");
    // exact vertical timing
    @(negedge clk) vsync = 1'b1;
    @(negedge clk) vsync = 1'b0;
    chk("R6 not yet at fall sample", {47'd0, dm}, {47'd0, 3'd0});
    @(negedge clk);
    m_clv = {m_csh[15:13], m_clv[12:11], m_csh[10:2], m_clv[1:0]};
    chk_all("R6 one cycle after vsync fall");
    chk("R4 bit placement drive/shift", {42'd0, dm, fs}, {42'd0, 3'd5, 8'h69});

    // shutter frame with exact bit positions
    send(mk_shut(10'h2A5, 12'h1C3, 10'h155), 48);
    hs_evt(1, 0);
    chk("R4 shutter fields", {18'd0, vc, hc, sl}, {18'd0, 10'h2A5, 12'h1C3, 10'h155});

    // rejects
    f = mk_shut(10'h3FF, 12'hFFF, 10'h3FF); f[7:0] = 8'b1000_0011;
    send(f, 48); hs_evt(1, 0); vs_evt(0);
    chk_all("R3 wrong chip code");
    send(mk_shut(10'h001, 12'h002, 10'h003), 47); hs_evt(1, 0);
    chk_all("R2 short frame");
    send(mk_shut(10'h001, 12'h002, 10'h003), 49); hs_evt(1, 0);
    chk_all("R2 long frame");
    f = mk_ctrl(3'd7, 2'd3, 1'b0, 8'hFF, 2'd0, 2'b11); f[9:8] = 2'b10;
    send(f, 48); @(negedge clk); vs_evt(0); hs_evt(1, 0);
    chk_all("R4 test category 10");
    f[9:8] = 2'b11; send(f, 48); vs_evt(0); hs_evt(1, 0);
    chk_all("R4 test category 11");

    // freeze
    send(mk_ctrl(3'd2, 2'd1, 1'b0, 8'h11, 2'd2, 2'b11), 48);
    send(mk_shut(10'h010, 12'h020, 10'h030), 48);
    @(negedge clk) busy = 1'b1;
    chk("R5 standby applied under busy", {48'd0, pwr}, {48'd0, 2'b11});
    @(negedge clk) busy = 1'b0;
    vs_evt(1); hs_evt(1, 1);
    chk_all("R8 blocked events");
    vs_evt(0); hs_evt(1, 0);
    chk_all("R8 commit after unblock");

    // overwrite
    send(mk_shut(10'h0AA, 12'h0BB, 10'h0CC), 48);
    send(mk_ctrl(3'd1, 2'd3, 1'b1, 8'h40, 2'd1, 2'b10), 48);
    send(mk_shut(10'h111, 12'h222, 10'h333), 48);
    hs_evt(1, 0); vs_evt(0);
    chk_all("R9 later shutter frame wins, control kept");
    chk("R5 code 10 is normal", {48'd0, pwr}, {48'd0, 2'b00});

    // constrained random mix
    for (int it = 0; it < 60; it++) begin
      int unsigned op = $urandom_range(0, 5);
      case (op)
        0, 1: begin
          f = mk_ctrl(3'($urandom), 2'($urandom), 1'($urandom), 8'($urandom),
                      2'($urandom), 2'($urandom));
          if ($urandom_range(0, 7) == 0) f[9:8] = 2'($urandom_range(2, 3));
          if ($urandom_range(0, 7) == 0) f[7:0] = 8'($urandom);
          send(f, ($urandom_range(0, 5) == 0) ? 47 : 48);
        end
        2: begin
          f = mk_shut(10'($urandom), 12'($urandom), 10'($urandom));
          send(f, ($urandom_range(0, 5) == 0) ? 49 : 48);
        end
        3: vs_evt(bit'($urandom_range(0, 3) == 0));
        default: hs_evt(bit'($urandom_range(0, 3) != 0), bit'($urandom_range(0, 3) == 0));
      endcase
      @(negedge clk);
      chk_all("R9 R8 R6 R7 random");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule